// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block reads one 16-bit word from a three-wire serial EEPROM whose words are selected by a 6-bit address. A single-cycle request carries the address. The block then drives the memory's select, clock and serial input lines to send a read command. It collects the sixteen bits the memory returns on its serial output and presents the word with a one-cycle completion strobe.

The command is an 11-bit frame sent most significant bit first. It contains two leading zero bits, a start bit that is always one, a 2-bit opcode and the address. Of the opcodes (read `10`, write `01`, erase `11`), only read is issued. The returned bits are placed least significant first: the first bit received lands in bit 0 of the result. The serial clock's half-period is a parameter counted in system clocks. Every pin toggle and every sample lies on a half-period boundary.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ee_cs`, `ee_sk`, `ee_di` and `rd_done` are low and the reader is idle.
- R2: An accepted request emits an 11-bit frame on `ee_di`, MSB first. Bits 10:9 are 0, bit 8 is 1, bits 7:6 are the read opcode `10` and bits 5:0 are `rd_addr`. Each bit is presented during a half-period with `ee_sk` low and `ee_cs` high. The first half-period starts on the cycle after the request is accepted.
- R3: Each frame bit stays on `ee_di` through the following half-period with `ee_sk` high.
- R4: Every serial clock half-period lasts exactly `HALF_CYC` system clocks (minimum 1). The 16 data clock pulses each consist of one high half-period followed by one low half-period.
- R5: Between the last frame bit and the first data clock there is exactly one half-period with `ee_cs` high and `ee_sk` and `ee_di` low.
- R6: `ee_do` is sampled in the last system cycle of each of the 16 high half-periods. The i-th sampled bit (i counted from 0) becomes bit i of `rd_data`.
- R7: After the last data pulse there is one half-period with `ee_cs` high and `ee_sk` and `ee_di` low. After that all three lines are low. Whenever `ee_cs` is low, `ee_sk` and `ee_di` are low.
- R8: `rd_done` is high for exactly one cycle, the cycle after the final half-period. `rd_data` is valid in that cycle and holds its value until the next completion.
- R9: A request raised while a read is in progress has no effect. The ongoing read keeps its address and timing, and no extra read follows.
- R10: A request raised in the cycle in which `rd_done` is high is accepted. Its frame starts on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, sampled when idle |
| rd_addr | input | ADDR_W | Word address for the request |
| rd_done | output | 1 | One-cycle completion strobe |
| rd_data | output | DATA_W | Word returned, LSB received first |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The completion strobe and the acceptance of the next request can fall in the same cycle. The bench raises a request exactly in the cycle in which `rd_done` is shown. It then expects the new frame's first half-period on the very next cycle, with no idle gap and with the finished word still intact. A second overlap is a request arriving in mid-read. The reference model keeps its expected pin stream unchanged, and the number of completion strobes must equal the number of accepted requests.

// File: rtl/mw_pkg.sv
package mw_pkg;

  // Two-bit opcodes carried in the command frame after the start bit
  typedef enum logic [1:0] {
    MW_OP_WRITE = 2'b01,
    MW_OP_READ  = 2'b10,
    MW_OP_ERASE = 2'b11
  } mw_op_e;

  // Frame overhead beyond the address: two idle zeros, start bit, opcode
  localparam int MW_FRAME_EXTRA = 5;

endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int HC = (HALF_CYC < 1) ? 1 : HALF_CYC;
  localparam int CW = (HC > 1) ? $clog2(HC) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R4: with a half-period above one cycle, ticks never come back to back
  if (HC > 1) begin : g_spacing
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end

endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word
);

  // New bits enter at the top and move down, so the first one ends in bit 0
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {bit_in, word[DATA_W-1:1]};
  end

endmodule

// File: rtl/mw_pin_decode.sv
module mw_pin_decode #(
  parameter int FRAME_W = 11,
  parameter int DATA_W  = 16,
  parameter int SW      = 6
) (
  input  logic [SW-1:0]      step,
  input  logic [FRAME_W-1:0] frame,
  output logic               cs,
  output logic               sk,
  output logic               di
);

  localparam int CMD_STEPS = 2 * FRAME_W;
  localparam int DATA0     = CMD_STEPS + 1;
  localparam int DATA_END  = DATA0 + 2 * DATA_W;

  logic [SW-1:0]      half_idx;
  logic [SW-1:0]      k;
  logic [FRAME_W-1:0] sh;

  always_comb begin
    half_idx = step >> 1;
    k        = step - SW'(DATA0);
    sh       = frame << half_idx;
    cs       = 1'b1;
    sk       = 1'b0;
    di       = 1'b0;
    if (step < SW'(CMD_STEPS)) begin
      sk = step[0];
      di = sh[FRAME_W-1];
    end else if (step >= SW'(DATA0) && step < SW'(DATA_END)) begin
      sk = ~k[0];
    end
  end

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int HALF_CYC = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  import mw_pkg::*;

  localparam int FRAME_W   = ADDR_W + MW_FRAME_EXTRA;
  localparam int CMD_STEPS = 2 * FRAME_W;
  localparam int DATA0     = CMD_STEPS + 1;
  localparam int TRAIL     = DATA0 + 2 * DATA_W;
  localparam int SW        = $clog2(TRAIL + 1);

  logic               busy;
  logic [SW-1:0]      step;
  logic [FRAME_W-1:0] frame_q;
  logic               tick;
  logic               start;
  logic               finish;
  logic               busy_nxt;
  logic [SW-1:0]      step_nxt;
  logic [FRAME_W-1:0] frame_nxt;
  logic               dec_cs, dec_sk, dec_di;
  logic [SW-1:0]      data_k;
  logic               sample_en;
  logic [DATA_W-1:0]  rx_word;

  mw_tick_gen #(.HALF_CYC(HALF_CYC)) i_tick (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  assign start     = rd_req && !busy;
  assign finish    = busy && tick && (step == SW'(TRAIL));
  assign busy_nxt  = start || (busy && !finish);
  assign frame_nxt = start ? {2'b00, 1'b1, MW_OP_READ, rd_addr} : frame_q;

  always_comb begin
    if (start || finish) step_nxt = '0;
    else if (tick)       step_nxt = step + 1'b1;
    else                 step_nxt = step;
  end

  mw_pin_decode #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .SW(SW)) i_dec (
    .step(step_nxt), .frame(frame_nxt),
    .cs(dec_cs), .sk(dec_sk), .di(dec_di)
  );

  // Sample at the close of each high half of the data phase
  assign data_k    = step - SW'(DATA0);
  assign sample_en = busy && tick && (step >= SW'(DATA0)) &&
                     (step < SW'(TRAIL)) && !data_k[0];

  mw_rx_shift #(.DATA_W(DATA_W)) i_rx (
    .clk(clk), .rst(rst), .shift_en(sample_en), .bit_in(ee_do), .word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      step    <= '0;
      frame_q <= '0;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
      ee_di   <= 1'b0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      busy    <= busy_nxt;
      step    <= step_nxt;
      frame_q <= frame_nxt;
      ee_cs   <= busy_nxt && dec_cs;
      ee_sk   <= busy_nxt && dec_sk;
      ee_di   <= busy_nxt && dec_di;
      rd_done <= finish;
      if (finish) rd_data <= rx_word;
    end
  end

  // R1: reset leaves every memory line and the strobe low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ee_cs && !ee_sk && !ee_di && !rd_done));

  // R3: data-in never moves on a rising serial clock
  assert_di_held_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_sk) |-> $stable(ee_di));

  // R7: a deselected memory sees quiet clock and data lines
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> (!ee_sk && !ee_di));

  // R8: the completion strobe lasts one cycle and comes with the select released
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);
  assert_done_released_R8: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> !ee_cs);

  // R9: a request during a read leaves the latched frame untouched
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_req && !finish) |=> $stable(frame_q));

endmodule

// File: tb/test_mw_eeprom_reader.sv
module test_mw_eeprom_reader;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic        rd_done;
  logic [15:0] rd_data;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;

  int tests = 0;
  int fails = 0;
  int dones = 0;
  int accepted = 0;
  logic [5:0] last_addr = '0;
  string idle_tag = "R1";

  logic [3:0]  q_pins[$];
  string       q_tag[$];
  logic [15:0] q_data[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_reader #(.HALF_CYC(HALF), .ADDR_W(6), .DATA_W(16)) i_mw_eeprom_reader (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [15:0] word_of(input logic [5:0] a);
    return {a, 4'b1001, a} ^ 16'h8421;
  endfunction

  // Behavioural memory: gathers the frame, then serves bits LSB first
  int          mem_n = 0;
  logic [10:0] mem_cmd = '0;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      mem_n = 0;
      ee_do = 1'b0;
    end else begin
      if (mem_n < 11) begin
        mem_cmd = {mem_cmd[9:0], ee_di};
      end else begin
        if (mem_n == 11) begin
          tests++;
          if (mem_cmd !== {5'b00110, last_addr}) begin
            fails++;
            $display("FAIL R2 frame: actual %b expected %b", mem_cmd, {5'b00110, last_addr});
          end
        end
        ee_do = word_of(mem_cmd[5:0])[mem_n - 11];
      end
      mem_n++;
    end
  end

  task automatic push_read(input logic [5:0] a, input string first_tag);
    logic [10:0] fr;
    fr = {2'b00, 1'b1, 2'b10, a};
    accepted++;
    last_addr = a;
    for (int s = 0; s < 22; s++)
      for (int h = 0; h < HALF; h++) begin
        q_pins.push_back({1'b1, 1'(s % 2), fr[10 - s/2], 1'b0});
        q_tag.push_back(s == 0 ? first_tag : ((s % 2) ? "R3" : "R2"));
        q_data.push_back('0);
      end
    for (int h = 0; h < HALF; h++) begin
      q_pins.push_back(4'b1000); q_tag.push_back("R5"); q_data.push_back('0);
    end
    for (int k = 0; k < 32; k++)
      for (int h = 0; h < HALF; h++) begin
        q_pins.push_back({1'b1, 1'(k % 2 == 0), 2'b00});
        q_tag.push_back("R4"); q_data.push_back('0);
      end
    for (int h = 0; h < HALF; h++) begin
      q_pins.push_back(4'b1000); q_tag.push_back("R7"); q_data.push_back('0);
    end
    q_pins.push_back(4'b0001); q_tag.push_back("R8"); q_data.push_back(word_of(a));
  endtask

  // One cycle: compare the current outputs, then set the inputs for the next edge
  task automatic cycle(input logic req, input logic [5:0] a, input string first_tag);
    logic [3:0]  act, exp;
    logic [15:0] expd;
    string       tag;
    @(negedge clk);
    act = {ee_cs, ee_sk, ee_di, rd_done};
    if (rd_done) dones++;
    if (q_pins.size() == 0) begin
      exp = 4'b0000; tag = idle_tag; expd = '0;
    end else begin
      exp = q_pins.pop_front(); tag = q_tag.pop_front(); expd = q_data.pop_front();
    end
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pins cs/sk/di/done: actual %b expected %b", tag, act, exp);
    end
    if (exp[0]) begin
      tests++;
      if (rd_data !== expd) begin
        fails++;
        $display("FAIL R6 data: actual %h expected %h", rd_data, expd);
      end
    end
    rd_req  = req;
    rd_addr = a;
    if (req && q_pins.size() == 0) push_read(a, first_tag);
  endtask

  task automatic run_until_idle();
    while (q_pins.size() > 0) cycle(1'b0, 6'd0, "R2");
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) cycle(1'b0, 6'd0, "R2");          // R1 reset state
    idle_tag = "R7";
    cycle(1'b1, 6'd0, "R2");
    run_until_idle();
    cycle(1'b1, 6'd63, "R2");
    repeat (50) cycle(1'b0, 6'd0, "R2");
    cycle(1'b1, 6'd5, "R2");                     // R9 ignored mid-read
    repeat (30) cycle(1'b1, 6'd9, "R2");         // R9 held request while busy
    while (q_pins.size() > 1) cycle(1'b0, 6'd0, "R2");
    cycle(1'b1, 6'h2A, "R10");                   // R10 request in the done cycle
    while (q_pins.size() > 1) cycle(1'b0, 6'd0, "R2");
    cycle(1'b1, 6'h15, "R10");
    run_until_idle();
    repeat (5) cycle(1'b0, 6'd0, "R2");
    tests++;                                      // R9 no extra reads
    if (dones != accepted) begin
      fails++;
      $display("FAIL R9 completions: actual %0d expected %0d", dones, accepted);
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R8 watchdog: actual no end expected end of run");
    finish_run();
  end

endmodule